// File: doc/BRIEF.md
# Framed Serial Peripheral Master

This block is a serial port master that exchanges words in the classic four-wire framing with clock, master-out, master-in and an active-low select. The clock polarity and the clock phase can each be chosen, and the word length runs from 4 to 16 bits. Every word goes out most significant bit first. At the same time the incoming line is shifted into a receive word. The SCK timing comes from a programmable divider, which sets each SCK half-period as a whole number of system clocks.

A word enters through a valid/ready handshake. The received word leaves on a one-cycle valid strobe, right-aligned with its upper bits zero. A single word forms a frame of its own. With phase 0, each word of a back-to-back stream gets its own frame, and select goes high between words so the slave can reload. With phase 1, a stream of words shares one frame: select stays low from the first word to the last. Polarity, phase, word length and divider are all sampled when a frame opens and are held until select rises again.

Top module: `spi_frame_master`

## Requirements
- R1: While the select output is high, MOSI is low and SCK follows the polarity input within one clock: 0 means idle low and 1 means idle high. After reset, select is high and no receive strobe is present.
- R2: The word length input is clamped to the range 4..16 (a value of 2 acts as 4 and a value of 20 acts as 16). The low bits of the transmit word go out most significant first, and the slave receives exactly those bits.
- R3: With phase 0, MOSI shows the first data bit one half-period after select falls, and the first SCK edge comes one half-period after that.
- R4: With phase 0, data is captured on the leading SCK edge and changed on the trailing edge. With polarity 1 this means capture on falling edges. With phase 1, data changes on the leading edge and is captured on the trailing edge. Each received word matches the bits the slave drove.
- R5: Select rises exactly one full SCK period, which is two half-periods, after the last capture edge of a frame.
- R6: With phase 0, back-to-back words each get their own frame: select goes high between words and falls once per word.
- R7: With phase 1, a word offered at the final capture edge of the current word continues the frame with no select pulse. Select falls only once for the whole stream.
- R8: One SCK half-period equals the divider input in system clocks. A divider value of 0 acts as 1.
- R9: A word is accepted only while the port is idle or at the final capture edge of a phase-1 word, so during a phase-0 frame txReady stays low. Each received word comes with a valid pulse exactly one clock long.
- R10: Polarity, phase, word length and divider are sampled when a frame opens. Changes to them during the frame have no effect until select rises.
- R11: A word produces exactly two SCK edges per bit, and SCK ends each frame at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgCpol | input | 1 | Clock polarity: idle SCK level |
| cfgCpha | input | 1 | Clock phase: 0 captures on the leading edge, 1 on the trailing edge |
| cfgWordLen | input | 5 | Word length in bits, clamped to 4..16 |
| cfgHalfDiv | input | 8 | System clocks per SCK half-period (0 acts as 1) |
| txValid | input | 1 | Transmit word offered |
| txData | input | 16 | Transmit word, right-aligned |
| txReady | output | 1 | Transmit word taken at this clock edge when txValid is high |
| rxValid | output | 1 | One-cycle strobe for a received word |
| rxData | output | 16 | Received word, right-aligned, upper bits zero |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssN | output | 1 | Active-low slave select |

## Verification
The bench builds the block with the default 16-bit maximum word and an 8-bit divider. It drives the divider at 0, 1, 2, 3 and 4. A divider of 1 makes the phase-1 chaining window a single clock wide, while 3 and 4 leave room to sample the half-period spacing of select, first bit and first edge. Word lengths of 2, 8, 12, 16 and 20 reach both clamps and the full width. The bench models a slave that is independent of the design and runs it in all four polarity and phase combinations.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  // Per-clock commands from the sequencer to the shifting datapath.
  typedef struct packed {
    logic start;        // frame opens: select goes low
    logic loadWord;     // transmit word enters the shifter
    logic drive;        // next bit onto MOSI
    logic capture;      // MISO sampled into the receive shifter
    logic lastCapture;  // capture of the final bit of a word
    logic sckToggle;    // SCK changes level
    logic ssHigh;       // frame closes: select goes high
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACTIVE,
    ST_GAP
  } ctrl_state_t;

endpackage

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_frame_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int MIN_W = 4,
  parameter int DIV_W = 8,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCpha,
  input  logic [LEN_W-1:0] cfgWordLen,
  input  logic [DIV_W-1:0] cfgHalfDiv,
  input  logic             txValid,
  output logic             txReady,
  output strobe_t          strobe,
  output logic [LEN_W-1:0] loadLen
);

  localparam int H_W = $clog2(2 * MAX_W + 3);

  ctrl_state_t      state;
  logic [H_W-1:0]   hCnt;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] heldDiv;
  logic [LEN_W-1:0] heldLen;
  logic             heldCpha;

  logic [LEN_W-1:0] lenIn;
  logic [DIV_W-1:0] divIn;
  logic [H_W-1:0]   hNext;
  logic [H_W-1:0]   lastCap;
  logic             tick;
  logic             activeTick;
  logic             boundary;
  logic             chain;

  // Clamp the live settings before they are latched.
  always_comb begin
    if (cfgWordLen < LEN_W'(MIN_W))      lenIn = LEN_W'(MIN_W);
    else if (cfgWordLen > LEN_W'(MAX_W)) lenIn = LEN_W'(MAX_W);
    else                                 lenIn = cfgWordLen;
    divIn = (cfgHalfDiv == '0) ? DIV_W'(1) : cfgHalfDiv;
  end

  // Half-period events: hNext counts half-periods since select fell.
  assign hNext      = hCnt + 1'b1;
  assign lastCap    = H_W'(heldLen) << 1;
  assign tick       = (state != ST_IDLE) && (divCnt == heldDiv - 1'b1);
  assign activeTick = (state == ST_ACTIVE) && tick;
  assign boundary   = activeTick && heldCpha && (hNext == lastCap);
  assign chain      = boundary && txValid;
  assign txReady    = (state == ST_IDLE) || boundary;
  assign loadLen    = (state == ST_IDLE) ? lenIn : heldLen;

  always_comb begin
    strobe             = '0;
    strobe.start       = (state == ST_IDLE) && txValid;
    strobe.loadWord    = strobe.start || chain;
    strobe.drive       = activeTick && hNext[0] && (hNext < lastCap);
    strobe.capture     = activeTick && !hNext[0] && (hNext >= H_W'(2)) && (hNext <= lastCap);
    strobe.lastCapture = activeTick && (hNext == lastCap);
    if (heldCpha)
      strobe.sckToggle = activeTick && (hNext >= H_W'(1)) && (hNext <= lastCap);
    else
      strobe.sckToggle = activeTick && (hNext >= H_W'(2)) && (hNext <= lastCap + 1'b1);
    strobe.ssHigh      = activeTick && (hNext == lastCap + H_W'(2));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      hCnt     <= '0;
      divCnt   <= '0;
      heldDiv  <= DIV_W'(1);
      heldLen  <= LEN_W'(MIN_W);
      heldCpha <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (txValid) begin
            state    <= ST_ACTIVE;
            hCnt     <= '0;
            divCnt   <= '0;
            heldDiv  <= divIn;
            heldLen  <= lenIn;
            heldCpha <= cfgCpha;
          end
        end
        ST_ACTIVE: begin
          if (tick) begin
            divCnt <= '0;
            if (hNext == lastCap + H_W'(2)) begin
              state <= ST_GAP;
              hCnt  <= '0;
            end else if (chain) begin
              hCnt <= '0;
            end else begin
              hCnt <= hNext;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (tick) begin
            state  <= ST_IDLE;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: latched settings do not move while a frame is open.
  assert_hold_cfg_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) != ST_IDLE) |->
      ($stable(heldCpha) && $stable(heldLen) && $stable(heldDiv)));

  // R2: the latched length always lies inside the clamp range.
  assert_len_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> (heldLen >= LEN_W'(MIN_W) && heldLen <= LEN_W'(MAX_W)));

  // R7: a word is taken mid-frame only in phase-1 mode.
  assert_chain_phase1_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && txValid && txReady) |-> heldCpha);

  // R8: half-period events on adjacent clocks only with a divider of one.
  assert_tick_rate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (activeTick && $past(activeTick)) |-> (heldDiv == DIV_W'(1)));

endmodule

// File: rtl/spi_frame_datapath.sv
module spi_frame_datapath
  import spi_frame_pkg::*;
#(
  parameter int MAX_W = 16,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCpol,
  input  strobe_t          strobe,
  input  logic [LEN_W-1:0] loadLen,
  input  logic [MAX_W-1:0] txData,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             ssN,
  output logic             rxValid,
  output logic [MAX_W-1:0] rxData
);

  logic [MAX_W-1:0] txShift;
  logic [MAX_W-1:0] rxShift;
  logic [LEN_W-1:0] padAmt;
  logic             framePol;

  assign padAmt = LEN_W'(MAX_W) - loadLen;

  // Transmit shifter: word left-aligned so the MSB leaves first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      mosi    <= 1'b0;
    end else begin
      if (strobe.loadWord) begin
        txShift <= txData << padAmt;
      end else if (strobe.drive) begin
        txShift <= {txShift[MAX_W-2:0], 1'b0};
      end
      if (strobe.drive)       mosi <= txShift[MAX_W-1];
      else if (strobe.ssHigh) mosi <= 1'b0;
    end
  end

  // Receive shifter and result register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strobe.lastCapture;
      if (strobe.lastCapture) rxData <= {rxShift[MAX_W-2:0], miso};
      if (strobe.loadWord)     rxShift <= '0;
      else if (strobe.capture) rxShift <= {rxShift[MAX_W-2:0], miso};
    end
  end

  // Select and serial clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ssN      <= 1'b1;
      sck      <= 1'b0;
      framePol <= 1'b0;
    end else begin
      if (strobe.start)       ssN <= 1'b0;
      else if (strobe.ssHigh) ssN <= 1'b1;
      if (strobe.start) framePol <= cfgCpol;
      if (strobe.sckToggle) sck <= ~sck;
      else if (ssN)         sck <= cfgCpol;
    end
  end

  // R1: the data line stays low outside a frame.
  assert_mosi_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    ssN |-> !mosi);

  // R1: the idle clock level tracks the polarity input.
  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ssN && $past(ssN) && $past(rstN)) |-> (sck == $past(cfgCpol)));

  // R9: the receive strobe never lasts more than one clock.
  assert_rx_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R11: the clock is back at the frame's idle level when select rises.
  assert_sck_rest_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ssN) |-> (sck == framePol));

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_frame_pkg::*;
#(
  parameter int MAX_W = 16,
  parameter int DIV_W = 8,
  localparam int LEN_W = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic [LEN_W-1:0] cfgWordLen,
  input  logic [DIV_W-1:0] cfgHalfDiv,
  input  logic             txValid,
  input  logic [MAX_W-1:0] txData,
  output logic             txReady,
  output logic             rxValid,
  output logic [MAX_W-1:0] rxData,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             ssN
);

  strobe_t          strobe;
  logic [LEN_W-1:0] loadLen;

  spi_frame_ctrl #(
    .MAX_W (MAX_W),
    .MIN_W (4),
    .DIV_W (DIV_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgCpha    (cfgCpha),
    .cfgWordLen (cfgWordLen),
    .cfgHalfDiv (cfgHalfDiv),
    .txValid    (txValid),
    .txReady    (txReady),
    .strobe     (strobe),
    .loadLen    (loadLen)
  );

  spi_frame_datapath #(
    .MAX_W (MAX_W)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .cfgCpol (cfgCpol),
    .strobe  (strobe),
    .loadLen (loadLen),
    .txData  (txData),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .ssN     (ssN),
    .rxValid (rxValid),
    .rxData  (rxData)
  );

endmodule

// File: tb/test_spi_frame_master.sv
module test_spi_frame_master;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_W = 16;
  localparam int DIV_W = 8;
  localparam int LEN_W = 5;

  logic             clk;
  logic             rstN;
  logic             cfgCpol;
  logic             cfgCpha;
  logic [LEN_W-1:0] cfgWordLen;
  logic [DIV_W-1:0] cfgHalfDiv;
  logic             txValid;
  logic [MAX_W-1:0] txData;
  logic             txReady;
  logic             rxValid;
  logic [MAX_W-1:0] rxData;
  logic             sck;
  logic             mosi;
  logic             miso;
  logic             ssN;

  spi_frame_master #(.MAX_W(MAX_W), .DIV_W(DIV_W)) i_spi_frame_master (
    .clk(clk), .rstN(rstN), .cfgCpol(cfgCpol), .cfgCpha(cfgCpha),
    .cfgWordLen(cfgWordLen), .cfgHalfDiv(cfgHalfDiv), .txValid(txValid),
    .txData(txData), .txReady(txReady), .rxValid(rxValid), .rxData(rxData),
    .sck(sck), .mosi(mosi), .miso(miso), .ssN(ssN)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Slave model, written from the framing rules alone.
  bit          mCpol, mCpha;
  int          mLen = 8;
  logic [15:0] slvWords [0:7];
  logic [15:0] slvGot   [0:7];
  logic [15:0] rxGot    [0:7];
  logic [15:0] txW      [0:7];
  int          sIdx, gIdx, sCnt, rxCnt, sckEdges, ssFalls;
  logic [15:0] sGot;
  time         lastCapT, riseT;
  bit          rxDouble, prevRx;

  always @(negedge ssN) begin
    ssFalls++;
    sCnt = 0;
    sGot = '0;
    if (!mCpha) miso = slvWords[sIdx][mLen-1];
  end

  always @(posedge ssN) riseT = $time;

  always @(sck) begin
    if (ssN === 1'b0) begin
      bit lead;
      bit doCap;
      sckEdges++;
      lead  = (sck != mCpol);
      doCap = mCpha ? !lead : lead;
      if (doCap) begin
        sGot = {sGot[14:0], mosi};
        sCnt++;
        lastCapT = $time;
        if (sCnt == mLen) begin
          slvGot[gIdx] = sGot;
          gIdx++;
          sIdx++;
          sCnt = 0;
          sGot = '0;
        end
      end else if (sCnt < mLen) begin
        miso = slvWords[sIdx][mLen-1-sCnt];
      end
    end
  end

  always @(negedge clk) begin
    if (rxValid === 1'b1) begin
      if (rxCnt < 8) rxGot[rxCnt] = rxData;
      rxCnt++;
    end
    if (prevRx && rxValid === 1'b1) rxDouble = 1;
    prevRx = (rxValid === 1'b1);
  end

  task automatic clearModel();
    sIdx = 0; gIdx = 0; sCnt = 0; rxCnt = 0; sckEdges = 0; ssFalls = 0;
    sGot = '0; rxDouble = 0; prevRx = 0; lastCapT = 0; riseT = 0;
    for (int i = 0; i < 8; i++) begin
      slvGot[i] = '0;
      rxGot[i]  = '0;
    end
  endtask

  task automatic sendWords(input int n, input bit flip);
    for (int i = 0; i < n; i++) begin
      txData  = txW[i];
      txValid = 1'b1;
      while (txReady !== 1'b1) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      if (flip && i == 0) begin
        cfgCpol    = ~cfgCpol;
        cfgCpha    = ~cfgCpha;
        cfgWordLen = 5'd5;
        cfgHalfDiv = 8'd7;
      end
    end
    txValid = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0; cfgCpol = 1'b1; cfgCpha = 1'b0; cfgWordLen = 5'd8;
    cfgHalfDiv = 8'd2; txValid = 1'b0; txData = '0; miso = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "reset ssN", ssN, 1);
    check("R1", "reset mosi", mosi, 0);
    check("R1", "reset sck idle high", sck, 1);
    check("R1", "reset rxValid", rxValid, 0);
    check("R9", "reset txReady", txReady, 1);
  endtask

  // R3, R4: phase-0 start-up spacing with polarity 1, divider 3.
  task automatic testPhase0Timing();
    @(negedge clk);
    cfgCpol = 1'b1; cfgCpha = 1'b0; cfgWordLen = 5'd8; cfgHalfDiv = 8'd3;
    mCpol = 1'b1; mCpha = 1'b0; mLen = 8;
    clearModel();
    txW[0] = 16'h00A5; slvWords[0] = 16'h003C;
    repeat (2) @(negedge clk);
    txData = txW[0]; txValid = 1'b1;
    @(posedge clk); #1;
    txValid = 1'b0;
    check("R3", "select low after accept", ssN, 0);
    check("R3", "mosi before first half-period", mosi, 0);
    repeat (2) @(posedge clk); #1;
    check("R3", "mosi still low at D-1", mosi, 0);
    check("R9", "txReady low inside phase-0 frame", txReady, 0);
    @(posedge clk); #1;
    check("R3", "first bit on mosi after one half-period", mosi, 1);
    check("R3", "sck not yet moved", sck, 1);
    repeat (3) @(posedge clk); #1;
    check("R4", "first edge is falling for polarity 1", sck, 0);
    wait (rxCnt >= 1);
    wait (ssN === 1'b1);
    repeat (4) @(negedge clk);
    check("R4", "phase-0 received word", rxGot[0], 16'h003C);
    check("R2", "phase-0 slave got word", slvGot[0], 16'h00A5);
    check("R5", "release delay divider 3", riseT - lastCapT, 2 * 3 * CLK_PERIOD);
  endtask

  task automatic runMode(input string tag, input bit pol, input bit pha,
                         input int lenCfg, input int effLen, input int divCfg,
                         input int divEff, input int n, input bit flip);
    logic [15:0] mask;
    mask = 16'((32'd1 << effLen) - 1);
    @(negedge clk);
    cfgCpol = pol; cfgCpha = pha; cfgWordLen = 5'(lenCfg); cfgHalfDiv = 8'(divCfg);
    mCpol = pol; mCpha = pha; mLen = effLen;
    clearModel();
    for (int i = 0; i < 8; i++) begin
      txW[i]      = 16'hB4E1 ^ 16'(i * 16'h3A7);
      slvWords[i] = 16'h5D2C + 16'(i * 16'h1119);
    end
    repeat (2) @(negedge clk);
    sendWords(n, flip);
    wait (rxCnt >= n);
    wait (ssN === 1'b1);
    if (flip) begin
      cfgCpol = pol; cfgCpha = pha; cfgWordLen = 5'(lenCfg); cfgHalfDiv = 8'(divCfg);
    end
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      check("R4", {tag, " received word"}, rxGot[i], slvWords[i] & mask);
      check("R2", {tag, " slave got word"}, slvGot[i], txW[i] & mask);
    end
    check("R9", {tag, " rx word count"}, rxCnt, n);
    check("R9", {tag, " rx strobe single cycle"}, rxDouble, 0);
    if (pha) check("R7", {tag, " select falls once"}, ssFalls, 1);
    else     check("R6", {tag, " select falls per word"}, ssFalls, n);
    check("R5", {tag, " release one period after capture"}, riseT - lastCapT,
          2 * divEff * CLK_PERIOD);
    check("R11", {tag, " sck edge count"}, sckEdges, 2 * effLen * n);
    check("R1", {tag, " idle select"}, ssN, 1);
    check("R1", {tag, " idle mosi"}, mosi, 0);
    check("R1", {tag, " idle sck"}, sck, pol);
  endtask

  initial begin
    testReset();
    testPhase0Timing();
    runMode("R6 pol0 pha0 stream", 1'b0, 1'b0, 8, 8, 2, 2, 3, 1'b0);
    runMode("R7 R10 pol1 pha1 stream", 1'b1, 1'b1, 12, 12, 1, 1, 3, 1'b1);
    runMode("pol0 pha1 full width", 1'b0, 1'b1, 16, 16, 4, 4, 2, 1'b0);
    runMode("R8 R2 short clamp div0", 1'b1, 1'b0, 2, 4, 0, 1, 2, 1'b0);
    runMode("R2 long clamp", 1'b0, 1'b0, 20, 16, 1, 1, 1, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule